// File: doc/BRIEF.md
# Endpoint Token History Queue

This block keeps a running record of the endpoint numbers that arrive with IN tokens. Each accepted token writes its 4-bit endpoint number into a circular buffer at the write pointer. The pointer then advances. The buffer never stalls and never refuses a token. Once every slot holds an entry, the next token overwrites the oldest one, and a sticky wrap flag records that the pointer has gone round at least once.

Software reads the history through two packed read-only 32-bit status words, chosen by a word index. The write pointer and the wrap flag sit beside the entries. With them, software can rebuild the order in which the tokens arrived: the oldest entry is at the pointer when the wrap flag is set, and at slot 0 when it is clear. A synchronous clear input empties the history.

Top module: `tkn_hist_queue`

## Requirements
- R1: After reset, every status word reads as zero.
- R2: An accepted token, with `tkn_vld` high and `clr` low, writes `tkn_ep` into the slot at the write pointer. The write pointer then increments by one.
- R3: A token accepted while the pointer is at slot DEPTH-1 returns the pointer to 0 and sets the wrap flag. Later tokens overwrite the oldest entries.
- R4: Once set, the wrap flag stays set through any number of tokens and clears only on `clr`.
- R5: Word index 0 carries the following fields:
  - the write pointer, zero-extended, in bits [4:0];
  - zero in bits [6:5];
  - the wrap flag in bit 7;
  - entry i, for i from 0 to 5, in bits [8+4i+3 : 8+4i].
- R6: Word index 1 carries entry 6+i, for i from 0 to 7, in bits [4i+3 : 4i].
- R7: With `clr` high at a clock edge, all entries, the pointer and the wrap flag become zero. A token presented in the same cycle is dropped.
- R8: A read, with `rd_en` high, captures the selected word into `rd_data` at the clock edge. A token pushed in the same cycle is not yet visible in that read.
- R9: Word indices 2 and above read as zero. Entry positions at or beyond DEPTH read as zero.
- R10: While `rd_en` is low, `rd_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the whole history |
| tkn_vld | input | 1 | An IN token is present this cycle |
| tkn_ep | input | 4 | Endpoint number of the token |
| rd_en | input | 1 | Capture the selected status word |
| rd_sel | input | SEL_W (2) | Status word index |
| rd_data | output | 32 | Registered status word |

## Verification
The bench builds two instances that share the same stimulus. The first uses DEPTH 14, which fills both status words completely and wraps after fourteen tokens, so the overwrite of the oldest entries can be seen in both words. The second uses DEPTH 3, which wraps after three tokens and leaves entry positions 3 to 13 unimplemented. That instance shows the zero fill of those positions and a pointer field narrower than five bits.

// File: rtl/tkn_hist_pkg.sv
package tkn_hist_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EP_W      = 4;
  localparam int unsigned PTR_FLD_W = 5;
  localparam int unsigned WRAP_POS  = 7;
  localparam int unsigned W0_BASE   = 8;
  localparam int unsigned W0_SLOTS  = 6;
  localparam int unsigned W1_SLOTS  = 8;
  localparam int unsigned MAX_SLOTS = W0_SLOTS + W1_SLOTS;
endpackage

// File: rtl/tkn_wptr.sv
module tkn_wptr #(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  output logic [PW-1:0] wptr,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wptr_d;
  logic          wrap_d;
  logic          en;

  always_comb begin
    wptr_d = wptr;
    wrap_d = wrap;
    en     = clr | push;
    if (clr) begin
      wptr_d = '0;
      wrap_d = 1'b0;
    end else if (push) begin
      if (wptr == LAST) begin
        wptr_d = '0;
        wrap_d = 1'b1;
      end else begin
        wptr_d = wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      wrap <= 1'b0;
    end else if (en) begin
      wptr <= wptr_d;
      wrap <= wrap_d;
    end
  end
endmodule

// File: rtl/tkn_store.sv
module tkn_store #(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned EP_W  = 4,
  parameter int unsigned PW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  push,
  input  logic [PW-1:0]         wptr,
  input  logic [EP_W-1:0]       ep,
  output logic [DEPTH*EP_W-1:0] slots
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EP_W-1:0] q;
    logic [EP_W-1:0] d;
    logic            en;

    always_comb begin
      en = clr | (push && (wptr == PW'(i)));
      d  = clr ? '0 : ep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign slots[i*EP_W +: EP_W] = q;
  end
endmodule

// File: rtl/tkn_pack.sv
module tkn_pack
  import tkn_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned PW    = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [DEPTH*EP_W-1:0] slots,
  input  logic [PW-1:0]         wptr,
  input  logic                  wrap,
  input  logic [SEL_W-1:0]      sel,
  output logic [WORD_W-1:0]     word
);
  logic [EP_W-1:0] pad [MAX_SLOTS];

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_pad
    if (i < DEPTH) begin : g_real
      assign pad[i] = slots[i*EP_W +: EP_W];
    end else begin : g_zero
      assign pad[i] = '0;
    end
  end

  logic [WORD_W-1:0] w0;
  logic [WORD_W-1:0] w1;

  always_comb begin
    w0 = '0;
    w1 = '0;
    w0[PTR_FLD_W-1:0] = PTR_FLD_W'(wptr);
    w0[WRAP_POS]      = wrap;
    for (int i = 0; i < W0_SLOTS; i++)
      w0[W0_BASE + i*EP_W +: EP_W] = pad[i];
    for (int i = 0; i < W1_SLOTS; i++)
      w1[i*EP_W +: EP_W] = pad[W0_SLOTS + i];
    if (sel == SEL_W'(0))      word = w0;
    else if (sel == SEL_W'(1)) word = w1;
    else                       word = '0;
  end
endmodule

// File: rtl/tkn_hist_queue.sv
module tkn_hist_queue
  import tkn_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tkn_vld,
  input  logic [EP_W-1:0]   tkn_ep,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0]         wptr_q;
  logic                  wrap_q;
  logic [DEPTH*EP_W-1:0] slots;
  logic [WORD_W-1:0]     word_sel;
  logic                  push;

  assign push = tkn_vld & ~clr;

  tkn_wptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
    .wptr(wptr_q), .wrap(wrap_q)
  );

  tkn_store #(.DEPTH(DEPTH), .EP_W(EP_W), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
    .wptr(wptr_q), .ep(tkn_ep), .slots(slots)
  );

  tkn_pack #(.DEPTH(DEPTH), .PW(PW), .SEL_W(SEL_W)) u_pack (
    .slots(slots), .wptr(wptr_q), .wrap(wrap_q), .sel(rd_sel),
    .word(word_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word_sel;
  end
endmodule

// File: rtl/tkn_hist_queue_chk.sv
module tkn_hist_queue_chk #(
  parameter int unsigned DEPTH = 14,
  parameter int unsigned PW    = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             tkn_vld,
  input logic             rd_en,
  input logic [SEL_W-1:0] rd_sel,
  input logic [31:0]      rd_data,
  input logic [PW-1:0]    wptr,
  input logic             wrap
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tkn_vld && !clr && wptr != LAST) |=> wptr == PW'($past(wptr) + 1'b1));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tkn_vld && !clr && wptr == LAST) |=> (wptr == '0 && wrap));

  // R4
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> wrap);

  // R7
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0 && !wrap));

  // R5
  w0_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_W'(0)) |=> rd_data[6:5] == 2'b00);

  // R9
  hi_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel > SEL_W'(1)) |=> rd_data == 32'h0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind tkn_hist_queue tkn_hist_queue_chk #(.DEPTH(DEPTH), .PW(PW), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tkn_vld(tkn_vld), .rd_en(rd_en),
  .rd_sel(rd_sel), .rd_data(rd_data), .wptr(wptr_q), .wrap(wrap_q)
);

// File: tb/tb_tkn_hist_queue.sv
`timescale 1ns/1ps
module tb_tkn_hist_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr, tkn_vld, rd_en;
  logic [3:0]  tkn_ep;
  logic [1:0]  rd_sel;
  logic [31:0] rd_a, rd_b;

  always #10 clk = ~clk;

  tkn_hist_queue #(.DEPTH(14)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tkn_vld(tkn_vld), .tkn_ep(tkn_ep),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_a));

  tkn_hist_queue #(.DEPTH(3)) dut_s (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tkn_vld(tkn_vld), .tkn_ep(tkn_ep),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_b));

  // vector: {clr, vld, ep}
  localparam int NV = 20;
  localparam logic [5:0] VEC [NV] = '{
    6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h19, 6'h1A,
    6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h1F, 6'h10, 6'h00, 6'h35, 6'h17, 6'h19};

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [3:0] mq [2][14];
  int         mptr [2];
  bit         mwrap [2];
  int         mdep [2] = '{14, 3};

  function automatic logic [31:0] mword(input int k, input int sel);
    logic [31:0] w = '0;
    if (sel == 0) begin
      w[4:0] = 5'(mptr[k]);
      w[7]   = mwrap[k];
      for (int i = 0; i < 6; i++) if (i < mdep[k]) w[8+4*i +: 4] = mq[k][i];
    end else if (sel == 1) begin
      for (int i = 0; i < 8; i++) if (6+i < mdep[k]) w[4*i +: 4] = mq[k][6+i];
    end
    return w;
  endfunction

  task automatic mupd(input bit c, input bit v, input logic [3:0] e);
    for (int k = 0; k < 2; k++) begin
      if (c) begin
        for (int i = 0; i < 14; i++) mq[k][i] = '0;
        mptr[k] = 0; mwrap[k] = 0;
      end else if (v) begin
        mq[k][mptr[k]] = e;
        if (mptr[k] == mdep[k]-1) begin mptr[k] = 0; mwrap[k] = 1; end
        else mptr[k]++;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] v);
    @(negedge clk);
    clr = v[5]; tkn_vld = v[4]; tkn_ep = v[3:0];
    @(negedge clk);
    clr = 0; tkn_vld = 0; tkn_ep = 0;
    mupd(v[5], v[4], v[3:0]);
  endtask

  task automatic rd(input int sel);
    @(negedge clk);
    rd_en = 1; rd_sel = 2'(sel);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held_a, held_b;
    rst_n = 0; clr = 0; tkn_vld = 0; tkn_ep = 0; rd_en = 0; rd_sel = 0;
    mupd(1'b1, 1'b0, 4'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, all words zero
    for (int s = 0; s < 4; s++) begin
      rd(s);
      chk("R1 big", rd_a, 32'h0);
      chk("R1 small", rd_b, 32'h0);
    end

    // R2 R3 R4 R5 R6 R7 R9: table walk
    for (int n = 0; n < NV; n++) begin
      step(VEC[n]);
      rd(0);
      chk("R2/R3/R5 word0 big", rd_a, mword(0, 0));
      chk("R3/R4/R9 word0 small", rd_b, mword(1, 0));
      rd(1);
      chk("R6/R7 word1 big", rd_a, mword(0, 1));
      chk("R9 word1 small", rd_b, mword(1, 1));
    end

    // R9: indices 2 and 3 read zero with data present
    for (int s = 2; s < 4; s++) begin
      rd(s);
      chk("R9 hi index big", rd_a, 32'h0);
      chk("R9 hi index small", rd_b, 32'h0);
    end

    // R8: read and push in the same cycle give the pre-push view
    held_a = mword(0, 0);
    held_b = mword(1, 0);
    @(negedge clk);
    tkn_vld = 1; tkn_ep = 4'hC; rd_en = 1; rd_sel = 0;
    @(negedge clk);
    tkn_vld = 0; rd_en = 0;
    mupd(1'b0, 1'b1, 4'hC);
    chk("R8 big", rd_a, held_a);
    chk("R8 small", rd_b, held_b);

    // R10: rd_data holds while rd_en is low, even across a push
    step(6'h1D);
    chk("R10 big", rd_a, held_a);
    chk("R10 small", rd_b, held_b);
    rd(0);
    chk("R2 after R10 big", rd_a, mword(0, 0));
    chk("R3 after R10 small", rd_b, mword(1, 0));

    // R7: a clear with no push empties everything
    step(6'h20);
    rd(0);
    chk("R7 word0 big", rd_a, 32'h0);
    chk("R7 word0 small", rd_b, 32'h0);

    finish_run();
  end
endmodule